// File: doc/BRIEF.md
# Page-Wrapping Write Buffer

This block sits between the byte stream of a serial write burst and a page-organised nonvolatile array. A burst begins with a start address. That address fixes the page and the first byte position within it. Each data byte that arrives is placed at the current position. The position then advances and folds back to the first byte of the same page after the last one, so a burst never reaches the next page. Any location that receives more than one byte keeps the last one.

On commit, the block walks the whole page in ascending order. For each location it reads the stored byte through a synchronous read port. It then writes back either the byte collected during the burst or, where nothing was collected, the old byte unchanged. A partial burst therefore still rewrites every location of the page. An abort discards the collected bytes without touching the array. The serial front end, command decoding and the array itself live outside this block.

Top module: `page_wrap_wbuf`

## Requirements
- R1: After reset, busy, rd_en and wr_en are 0, the page base is 0 and no location is marked written, so a commit issued right after reset rewrites page 0 with its existing contents.
- R2: An accepted start sets the page base to start_addr with its low 7 bits cleared and the write position to those low 7 bits, and it discards every byte collected earlier.
- R3: Each accepted byte is stored at the write position, which then advances by one modulo 128; the byte after offset 127 lands on offset 0 of the same page, never in the next page.
- R4: A burst may carry any number of bytes, including more than 128; every byte is accepted and each location keeps the last byte stored to it.
- R5: An accepted commit raises busy in the next cycle, and from that cycle rd_en is high for 128 consecutive cycles with rd_addr stepping from page base + 0 to page base + 127.
- R6: One cycle after each read, wr_en is high with wr_addr equal to that read address, and wr_data is the collected byte if that offset was written in the burst, otherwise the value returned on rd_data.
- R7: busy falls in the cycle after the write to offset 127. The collected-byte marks are then cleared, and the write position is kept, so later bytes without a new start continue where the burst stopped.
- R8: An accepted abort clears every collected-byte mark and sets the write position to offset 0 of the current page without any read or write of the array; wr_en is high only while busy.
- R9: When several controls are high in the same idle cycle, only the one with the highest priority takes effect: abort, then commit, then start, then byte. Lower-priority controls in that cycle are dropped.
- R10: While busy, start, byte, commit and abort are all ignored. Neither the page being written, nor the write position, nor the collected bytes change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_valid | input | 1 | Begin a burst at start_addr |
| start_addr | input | 16 | Byte address of the first byte of the burst |
| byte_valid | input | 1 | A data byte is present |
| byte_data | input | 8 | Data byte |
| commit | input | 1 | Write the merged page to the array |
| abort | input | 1 | Discard the collected bytes |
| busy | output | 1 | Page write sequence in progress |
| rd_en | output | 1 | Array read request |
| rd_addr | output | 16 | Array read address |
| rd_data | input | 8 | Array read data, valid one cycle after rd_en |
| wr_en | output | 1 | Array write strobe |
| wr_addr | output | 16 | Array write address |
| wr_data | output | 8 | Array write data |

## Verification
Properties watch the ordering of the page walk on every cycle. Busy and the first read follow a commit, reads step by one, each write repeats the previous read's address, and busy ends after offset 127. They also check that nothing reaches the array while idle. The placement of bytes cannot be seen by a property on the ports: wrap-around, last-write-wins, the choice between new and old data, the effect of abort and priority, and the inputs ignored while busy. The bench shows these by keeping its own page model and comparing the array contents after each sweep over a range of burst lengths and start offsets.

// File: rtl/pwb_pkg.sv
// Package for the page-wrapping write buffer.
// Holds the state type of the page sweep sequencer.
package pwb_pkg;

    typedef enum logic {
        SW_IDLE = 1'b0,
        SW_RUN  = 1'b1
    } sweep_st_e;

endpackage

// File: rtl/pwb_cursor.sv
// Tracks the page base and the byte position of the current burst.
// Assumes at most one of zero/load/step is high per cycle (the top decides priority).
module pwb_cursor #(
    parameter int ADDR_W = 16,
    parameter int OFF_W  = 7
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    zero,
    input  logic                    load,
    input  logic [ADDR_W-1:0]       load_addr,
    input  logic                    step,
    output logic [ADDR_W-OFF_W-1:0] base_hi,
    output logic [OFF_W-1:0]        ptr
);

    // Update page base and position; the position wraps inside the page.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_hi <= '0;
            ptr     <= '0;
        end else if (zero) begin
            ptr     <= '0;
        end else if (load) begin
            base_hi <= load_addr[ADDR_W-1:OFF_W];
            ptr     <= load_addr[OFF_W-1:0];
        end else if (step) begin
            ptr     <= ptr + {{(OFF_W-1){1'b0}}, 1'b1};
        end
    end

endmodule

// File: rtl/pwb_store.sv
// Page-sized byte buffer with one written-mark per slot.
// Assumes clr and wr are never high together. Data slots are not reset, and
// the mark tells whether a slot holds a byte of the current burst.
module pwb_store #(
    parameter int DEPTH  = 128,
    parameter int OFF_W  = 7,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              wr,
    input  logic [OFF_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [OFF_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_byte,
    output logic              rd_hit
);

    logic [DEPTH-1:0]  mark_vec;
    logic [DATA_W-1:0] slot_q [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        logic              v_q;
        logic [DATA_W-1:0] d_q;

        // Written-mark of this slot: set on store, cleared on reset or clr.
        always_ff @(posedge clk) begin
            if (!rst_n || clr) begin
                v_q <= 1'b0;
            end else if (wr && (wr_idx == OFF_W'(g))) begin
                v_q <= 1'b1;
            end
        end

        // Data of this slot: the last byte stored here wins.
        always_ff @(posedge clk) begin
            if (wr && (wr_idx == OFF_W'(g))) begin
                d_q <= wr_data;
            end
        end

        assign mark_vec[g] = v_q;
        assign slot_q[g]   = d_q;
    end

    // Lookup of the slot selected by the sweep.
    always_comb begin
        rd_byte = slot_q[rd_idx];
        rd_hit  = mark_vec[rd_idx];
    end

endmodule

// File: rtl/pwb_sweep.sv
// Walks one page: reads each location, then one cycle later writes the
// merged byte back. Assumes a synchronous array read with one cycle latency
// and a base that stays fixed while busy.
module pwb_sweep
    import pwb_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int OFF_W  = 7,
    parameter int DATA_W = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    go,
    input  logic [ADDR_W-OFF_W-1:0] base_hi,
    input  logic                    slot_hit,
    input  logic [DATA_W-1:0]       slot_byte,
    input  logic [DATA_W-1:0]       rd_data,
    output logic [OFF_W-1:0]        sel_idx,
    output logic                    busy,
    output logic                    done,
    output logic                    rd_en,
    output logic [ADDR_W-1:0]       rd_addr,
    output logic                    wr_en,
    output logic [ADDR_W-1:0]       wr_addr,
    output logic [DATA_W-1:0]       wr_data
);

    sweep_st_e        state;
    logic [OFF_W:0]   cnt;
    logic             wr_pend;
    logic [OFF_W-1:0] wr_idx;

    // Read and write ports plus the merge choice.
    always_comb begin
        busy    = (state == SW_RUN);
        rd_en   = busy && !cnt[OFF_W];
        rd_addr = {base_hi, cnt[OFF_W-1:0]};
        wr_en   = wr_pend;
        wr_addr = {base_hi, wr_idx};
        wr_data = slot_hit ? slot_byte : rd_data;
        done    = wr_pend && (wr_idx == {OFF_W{1'b1}});
        sel_idx = wr_idx;
    end

    // Sequencer: read counter, write stage one cycle behind, run/idle state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= SW_IDLE;
            cnt     <= '0;
            wr_pend <= 1'b0;
            wr_idx  <= '0;
        end else begin
            wr_pend <= rd_en;
            wr_idx  <= cnt[OFF_W-1:0];
            case (state)
                SW_IDLE: begin
                    if (go) begin
                        state <= SW_RUN;
                        cnt   <= '0;
                    end
                end
                SW_RUN: begin
                    if (rd_en) begin
                        cnt <= cnt + {{OFF_W{1'b0}}, 1'b1};
                    end
                    if (done) begin
                        state <= SW_IDLE;
                    end
                end
                default: state <= SW_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/page_wrap_wbuf.sv
// Top of the page-wrapping write buffer. Arbitrates the controls
// (abort > commit > start > byte, all ignored while busy) and wires the
// cursor, buffer and sweep together. Assumes PAGE_BYTES is a power of two.
module page_wrap_wbuf #(
    parameter int ADDR_W     = 16,
    parameter int PAGE_BYTES = 128,
    parameter int DATA_W     = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_valid,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic              byte_valid,
    input  logic [DATA_W-1:0] byte_data,
    input  logic              commit,
    input  logic              abort,
    output logic              busy,
    output logic              rd_en,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic [DATA_W-1:0] rd_data,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data
);

    localparam int OFF_W = $clog2(PAGE_BYTES);

    logic                    take_abort, take_commit, take_start, take_byte;
    logic [ADDR_W-OFF_W-1:0] base_hi;
    logic [OFF_W-1:0]        ptr;
    logic [OFF_W-1:0]        sel_idx;
    logic [DATA_W-1:0]       slot_byte;
    logic                    slot_hit;
    logic                    sweep_done;

    // Control priority; nothing is taken while a page write runs.
    always_comb begin
        take_abort  = !busy && abort;
        take_commit = !busy && !abort && commit;
        take_start  = !busy && !abort && !commit && start_valid;
        take_byte   = !busy && !abort && !commit && !start_valid && byte_valid;
    end

    pwb_cursor #(
        .ADDR_W (ADDR_W),
        .OFF_W  (OFF_W)
    ) u_cursor (
        .clk       (clk),
        .rst_n     (rst_n),
        .zero      (take_abort),
        .load      (take_start),
        .load_addr (start_addr),
        .step      (take_byte),
        .base_hi   (base_hi),
        .ptr       (ptr)
    );

    pwb_store #(
        .DEPTH  (PAGE_BYTES),
        .OFF_W  (OFF_W),
        .DATA_W (DATA_W)
    ) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (take_abort || take_start || sweep_done),
        .wr      (take_byte),
        .wr_idx  (ptr),
        .wr_data (byte_data),
        .rd_idx  (sel_idx),
        .rd_byte (slot_byte),
        .rd_hit  (slot_hit)
    );

    pwb_sweep #(
        .ADDR_W (ADDR_W),
        .OFF_W  (OFF_W),
        .DATA_W (DATA_W)
    ) u_sweep (
        .clk       (clk),
        .rst_n     (rst_n),
        .go        (take_commit),
        .base_hi   (base_hi),
        .slot_hit  (slot_hit),
        .slot_byte (slot_byte),
        .rd_data   (rd_data),
        .sel_idx   (sel_idx),
        .busy      (busy),
        .done      (sweep_done),
        .rd_en     (rd_en),
        .rd_addr   (rd_addr),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data)
    );

endmodule

// File: rtl/page_wrap_wbuf_chk.sv
// Checker for the page-wrapping write buffer, bound to the top module.
// Watches only the port-level ordering of the page walk.
module page_wrap_wbuf_chk #(
    parameter int ADDR_W = 16,
    parameter int OFF_W  = 7
) (
    input logic              clk,
    input logic              rst_n,
    input logic              commit,
    input logic              abort,
    input logic              busy,
    input logic              rd_en,
    input logic [ADDR_W-1:0] rd_addr,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr
);

    AST_COMMIT_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && commit && !abort) |=> (busy && rd_en && rd_addr[OFF_W-1:0] == '0)); // R5

    AST_READ_STEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && $past(rd_en)) |-> (rd_addr == $past(rd_addr) + 1'b1)); // R5

    AST_WRITE_TRAILS_READ: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> ($past(rd_en) && wr_addr == $past(rd_addr))); // R6

    AST_LAST_WRITE_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr[OFF_W-1:0] == {OFF_W{1'b1}}) |=> !busy); // R7

    AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !(wr_en && wr_addr[OFF_W-1:0] == {OFF_W{1'b1}})) |=> busy); // R10

    AST_QUIET_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!rd_en && !wr_en)); // R8

endmodule

bind page_wrap_wbuf page_wrap_wbuf_chk #(
    .ADDR_W (ADDR_W),
    .OFF_W  (OFF_W)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .commit  (commit),
    .abort   (abort),
    .busy    (busy),
    .rd_en   (rd_en),
    .rd_addr (rd_addr),
    .wr_en   (wr_en),
    .wr_addr (wr_addr)
);

// File: tb/tb_page_wrap_wbuf.sv
// Bench: drives bursts of many lengths and offsets, keeps its own page model
// and array mirror, and compares the array after every page sweep.
module tb_page_wrap_wbuf;

    localparam int CLK_PERIOD = 10;
    localparam int MEM_N      = 1024;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        start_valid;
    logic [15:0] start_addr;
    logic        byte_valid;
    logic [7:0]  byte_data;
    logic        commit;
    logic        abort;
    logic        busy;
    logic        rd_en;
    logic [15:0] rd_addr;
    logic [7:0]  rd_data;
    logic        wr_en;
    logic [15:0] wr_addr;
    logic [7:0]  wr_data;

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    logic [7:0]  ram       [MEM_N];
    logic [7:0]  model_mem [MEM_N];
    logic [7:0]  m_buf     [128];
    bit          m_mark    [128];
    logic [15:0] m_base;
    int          m_ptr;

    always #(CLK_PERIOD/2) clk = ~clk;

    page_wrap_wbuf dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_valid (start_valid),
        .start_addr  (start_addr),
        .byte_valid  (byte_valid),
        .byte_data   (byte_data),
        .commit      (commit),
        .abort       (abort),
        .busy        (busy),
        .rd_en       (rd_en),
        .rd_addr     (rd_addr),
        .rd_data     (rd_data),
        .wr_en       (wr_en),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data)
    );

    // Synchronous array model, low 10 address bits only.
    always_ff @(posedge clk) begin
        if (rd_en) rd_data <= ram[rd_addr[9:0]];
        if (wr_en) ram[wr_addr[9:0]] <= wr_data;
    end

    function automatic logic [7:0] pat(input int a);
        return 8'((a * 7 + 3) & 255);
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic clear_in();
        start_valid = 1'b0;
        start_addr  = '0;
        byte_valid  = 1'b0;
        byte_data   = '0;
        commit      = 1'b0;
        abort       = 1'b0;
    endtask

    // One idle-state cycle of controls; the model follows the priority of R9.
    task automatic step(input bit st, input logic [15:0] sa, input bit bv,
                        input logic [7:0] bd, input bit cm, input bit ab);
        start_valid = st; start_addr = sa;
        byte_valid  = bv; byte_data  = bd;
        commit      = cm; abort      = ab;
        @(negedge clk);
        clear_in();
        if (ab) begin
            for (int i = 0; i < 128; i++) m_mark[i] = 0;
            m_ptr = 0;
        end else if (cm) begin
            // sweep checked by the caller
        end else if (st) begin
            m_base = sa & 16'hFF80;
            m_ptr  = int'(sa & 16'h007F);
            for (int i = 0; i < 128; i++) m_mark[i] = 0;
        end else if (bv) begin
            m_buf[m_ptr]  = bd;
            m_mark[m_ptr] = 1;
            m_ptr = (m_ptr + 1) % 128;
        end
    endtask

    task automatic tb_start(input logic [15:0] a);
        step(1, a, 0, 8'h00, 0, 0);
    endtask

    task automatic tb_byte(input logic [7:0] d);
        step(0, 16'h0, 1, d, 0, 0);
    endtask

    // Checks the page walk that follows an accepted commit (R5, R6, R7, R10).
    task automatic sweep_check(input bit noise);
        logic [7:0] pg [128];
        int e_seq = 0;
        int e_dat = 0;
        int e_mem = 0;
        for (int i = 0; i < 128; i++)
            pg[i] = m_mark[i] ? m_buf[i] : model_mem[(int'(m_base) + i) % MEM_N];
        chk(busy === 1'b1 && rd_en === 1'b1 && rd_addr === m_base, "R5",
            "sweep opens at page base", int'(rd_addr), int'(m_base));
        for (int i = 1; i <= 128; i++) begin
            if (noise) begin
                start_valid = 1'b1; start_addr = 16'(i * 3);
                byte_valid  = 1'b1; byte_data  = 8'(i);
                commit      = 1'b1; abort      = 1'(i % 2);
            end
            @(negedge clk);
            if (!(wr_en === 1'b1 && wr_addr === m_base + 16'(i - 1))) e_seq++;
            if (i < 128 && !(rd_en === 1'b1 && rd_addr === m_base + 16'(i))) e_seq++;
            if (i == 128 && rd_en !== 1'b0) e_seq++;
            if (wr_data !== pg[i-1]) e_dat++;
        end
        clear_in();
        @(negedge clk);
        chk(busy === 1'b0 && wr_en === 1'b0, "R7", "busy ends after last write",
            int'({busy, wr_en}), 0);
        chk(e_seq == 0, "R5", "read/write address order", e_seq, 0);
        chk(e_dat == 0, "R6", "merged write data", e_dat, 0);
        for (int i = 0; i < 128; i++) begin
            model_mem[(int'(m_base) + i) % MEM_N] = pg[i];
            m_mark[i] = 0;
        end
        for (int a = 0; a < MEM_N; a++)
            if (ram[a] !== model_mem[a]) e_mem++;
        chk(e_mem == 0, noise ? "R10" : "R6", "array contents after sweep", e_mem, 0);
    endtask

    task automatic tb_commit(input bit noise);
        step(0, 16'h0, 0, 8'h00, 1, 0);
        sweep_check(noise);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual hung expected done");
            $display("[TB] %0d tests run, %0d failed", checks, fails);
            $finish;
        end
    end

    initial begin
        for (int a = 0; a < MEM_N; a++) begin
            ram[a]       = pat(a);
            model_mem[a] = pat(a);
        end
        for (int i = 0; i < 128; i++) begin
            m_buf[i]  = '0;
            m_mark[i] = 0;
        end
        m_base = '0;
        m_ptr  = 0;
        clear_in();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk(busy === 1'b0 && rd_en === 1'b0 && wr_en === 1'b0, "R1",
            "outputs idle in reset", int'({busy, rd_en, wr_en}), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: commit right after reset keeps page 0 unchanged.
        tb_commit(0);
        begin
            int bad = 0;
            for (int i = 0; i < 128; i++) if (ram[i] !== pat(i)) bad++;
            chk(bad == 0, "R1", "page 0 unchanged by empty commit", bad, 0);
        end

        // R2/R3: short burst mid-page; then R7 position kept after commit.
        tb_start(16'h0105);
        for (int k = 0; k < 5; k++) tb_byte(8'hA0 + 8'(k));
        tb_commit(0);
        chk(ram[10'h105] === 8'hA0, "R2", "first byte at start offset",
            int'(ram[10'h105]), 8'hA0);
        tb_byte(8'h55);
        tb_commit(0);
        chk(ram[10'h10A] === 8'h55, "R7", "position kept across commit",
            int'(ram[10'h10A]), 8'h55);

        // R3: wrap from offset 127 back to offset 0 of the same page.
        tb_start(16'h027C);
        for (int k = 0; k < 10; k++) tb_byte(8'hC0 + 8'(k));
        tb_commit(0);
        chk(ram[10'h200] === 8'hC4, "R3", "wrapped byte at page offset 0",
            int'(ram[10'h200]), 8'hC4);
        chk(ram[10'h280] === pat(10'h280), "R3", "next page untouched",
            int'(ram[10'h280]), int'(pat(10'h280)));

        // R4: 200-byte burst, last write wins.
        tb_start(16'h0300);
        for (int k = 0; k < 200; k++) tb_byte(8'(k));
        tb_commit(0);
        chk(ram[10'h300] === 8'd128, "R4", "offset 0 overwritten",
            int'(ram[10'h300]), 128);
        chk(ram[10'h347] === 8'd199, "R4", "last byte of burst",
            int'(ram[10'h347]), 199);
        chk(ram[10'h348] === 8'd72, "R4", "slot written once",
            int'(ram[10'h348]), 72);

        // R2: high page address, base keeps upper bits.
        tb_start(16'hFE85);
        for (int k = 0; k < 3; k++) tb_byte(8'h30 + 8'(k));
        tb_commit(0);
        chk(ram[10'h285] === 8'h30, "R2", "high page start offset",
            int'(ram[10'h285]), 8'h30);

        // R8: abort discards bytes and writes nothing.
        tb_start(16'h0190);
        for (int k = 0; k < 3; k++) tb_byte(8'h60 + 8'(k));
        step(0, 16'h0, 0, 8'h00, 0, 1);
        begin
            int seen = 0;
            for (int k = 0; k < 5; k++) begin
                @(negedge clk);
                if (wr_en !== 1'b0 || busy !== 1'b0) seen++;
            end
            chk(seen == 0, "R8", "no write after abort", seen, 0);
        end
        tb_byte(8'h71);
        tb_byte(8'h72);
        tb_commit(0);
        chk(ram[10'h180] === 8'h71, "R8", "byte after abort at offset 0",
            int'(ram[10'h180]), 8'h71);
        chk(ram[10'h190] === pat(10'h190), "R8", "aborted byte dropped",
            int'(ram[10'h190]), int'(pat(10'h190)));

        // R9: same-cycle controls.
        step(1, 16'h0040, 1, 8'hEE, 0, 0);
        tb_byte(8'h11);
        step(0, 16'h0, 1, 8'hDD, 1, 0);
        sweep_check(0);
        chk(ram[10'h040] === 8'h11, "R9", "byte with start dropped",
            int'(ram[10'h040]), 8'h11);
        chk(ram[10'h041] === pat(10'h041), "R9", "byte with commit dropped",
            int'(ram[10'h041]), int'(pat(10'h041)));
        tb_start(16'h0000);
        tb_byte(8'h99);
        step(0, 16'h0, 0, 8'h00, 1, 1);
        chk(busy === 1'b0, "R9", "abort beats commit", int'(busy), 0);
        tb_commit(0);
        chk(ram[10'h000] === pat(0), "R9", "aborted byte not written",
            int'(ram[10'h000]), int'(pat(0)));

        // R10: controls during the sweep have no effect.
        tb_start(16'h0220);
        for (int k = 0; k < 4; k++) tb_byte(8'h40 + 8'(k));
        tb_commit(1);
        tb_byte(8'h5A);
        tb_commit(0);
        chk(ram[10'h224] === 8'h5A, "R10", "position unchanged by busy inputs",
            int'(ram[10'h224]), 8'h5A);

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end

endmodule